// File: doc/BRIEF.md
# Set/Clear/Toggle Aliased Register Bank

This block is a bank of 32-bit control registers on a simple word-wide read/write bus. Each aliased register has four adjacent word slots. The first slot is the register itself. The second slot ORs the write data into the register, the third clears the bits that are set in the write data, and the fourth flips them. A driver can therefore change a few control bits in one bus write, without reading the register first. After the aliased groups come a few plain registers that have only one slot each. Every stored register is driven out in parallel so that downstream logic can use it.

A request lasts one cycle and is answered in the next cycle, with read data or an error flag. Reset loads a fixed value into each register. Registers marked as PLL controls also get their lock flag, bit 31, set on top of that value.

Top module: `setclr_reg_bank`

## Requirements
- R1: The word index is the byte address shifted right by 2. Group g uses word indices 4g (base), 4g+1 (set), 4g+2 (clear) and 4g+3 (toggle). Word index 4*NUM_GROUPS+p addresses plain register p, which is register number NUM_GROUPS+p.
- R2: A write to a set slot leaves the base register equal to its old value OR the write data.
- R3: A write to a clear slot leaves the base register equal to its old value AND NOT the write data.
- R4: A write to a toggle slot leaves the base register equal to its old value XOR the write data.
- R5: A read of any of the four slots of a group returns the current base register of that group.
- R6: A write to a base slot or to a plain register slot replaces all 32 bits.
- R7: A request with byte address bits [1:0] not equal to 0, or with byte enables other than 4'hF, gets busError=1. A write of this kind changes no register, and a read of this kind returns 0.
- R8: A request to a word index at or above 4*NUM_GROUPS+NUM_PLAIN (18 by default) gets busError=1. It changes no register, and a read returns 0.
- R9: In the default configuration the reset values of registers 0..5 are 0x80013001, 0x1018101B, 0x80012000, 0x00000000, 0x00000012 and 0x00000000. Bit 31 is forced to 1 for every group whose LOCK_MASK bit is set (groups 0 and 2 by default).
- R10: A request is answered with busReady=1 in the next cycle, and busReady is 0 when there was no request. A read issued in the cycle right after a write sees the updated value.
- R11: regFile bits [32k+31:32k] always carry register k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | A request is present this cycle |
| busWrite | input | 1 | 1 for a write request, 0 for a read request |
| busAddr | input | ADDR_W | Byte address |
| busByteEn | input | 4 | Byte enables; must be 4'hF |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle after the request |
| busReady | output | 1 | Response strobe, one cycle after the request |
| busError | output | 1 | Error response flag |
| regFile | output | (NUM_GROUPS+NUM_PLAIN)*32 | All stored registers, packed |

## Verification
The hardest case to reach from the ports is an alias write followed at once by a read of the same register, because a response registered one cycle late could still show stale data. The bench issues every alias operation with several bit patterns back to back with a read of the base slot, and it compares the result with an arithmetic model. It also sweeps every word index in the address space, so the errors past the implemented range and the way alias reads fold onto the base register are both covered completely.

// File: rtl/alias_bank_pkg.sv
package alias_bank_pkg;

  // The operation code is the same as the slot offset inside a group.
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } bankOp_e;

  typedef struct packed {
    logic    act;
    logic    wr;
    logic    err;
    bankOp_e op;
  } bankStrb_t;

  localparam logic [31:0] LOCK_BIT = 32'h8000_0000;

  // Reset value of each register number, before the lock bit is applied.
  function automatic logic [31:0] baseReset(input int k);
    case (k)
      0:       baseReset = 32'h0001_3001;
      1:       baseReset = 32'h1018_101B;
      2:       baseReset = 32'h0001_2000;
      4:       baseReset = 32'h0000_0012;
      default: baseReset = 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/alias_bank_ctrl.sv
module alias_bank_ctrl
  import alias_bank_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_GROUPS = 4,
  parameter int NUM_PLAIN  = 2,
  parameter int SEL_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  output bankStrb_t         strb,
  output logic [SEL_W-1:0]  regSel
);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int ALIAS_END = 4 * NUM_GROUPS;
  localparam int NSLOT     = ALIAS_END + NUM_PLAIN;

  logic [IDX_W-1:0] wordIdx;
  logic [31:0]      idxWide;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign idxWide = 32'(wordIdx);

  always_comb begin
    strb.act = busValid;
    strb.wr  = busWrite;
    strb.err = (busAddr[1:0] != 2'b00) || (busByteEn != 4'hF) ||
               (idxWide >= 32'(NSLOT));
    if (idxWide < 32'(ALIAS_END)) begin
      regSel  = SEL_W'(idxWide >> 2);
      strb.op = bankOp_e'(idxWide[1:0]);
    end else begin
      regSel  = SEL_W'(idxWide - 32'(ALIAS_END) + 32'(NUM_GROUPS));
      strb.op = OP_WRITE;
    end
  end

  AST_PARTIAL_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busByteEn != 4'hF) |-> strb.err) else $error("AST_PARTIAL_ERR"); // R7
  AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busAddr[1:0] != 2'b00) |-> strb.err) else $error("AST_MISALIGN_ERR"); // R7

endmodule

// File: rtl/alias_bank_data.sv
module alias_bank_data
  import alias_bank_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_PLAIN  = 2,
  parameter int SEL_W      = 3,
  parameter logic [NUM_GROUPS-1:0] LOCK_MASK = '1
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  bankStrb_t                            strb,
  input  logic [SEL_W-1:0]                     regSel,
  input  logic [31:0]                          wdata,
  output logic [31:0]                          rdata,
  output logic                                 ready,
  output logic                                 err,
  output logic [(NUM_GROUPS+NUM_PLAIN)*32-1:0] regFile
);
  localparam int NREG = NUM_GROUPS + NUM_PLAIN;
  localparam logic [NREG-1:0] LOCK_EXT = NREG'(LOCK_MASK);

  logic [31:0] regArr [NREG];
  logic [31:0] selOld;
  logic        wrOk;

  assign wrOk   = strb.act && strb.wr && !strb.err;
  assign selOld = regArr[regSel];

  for (genvar k = 0; k < NREG; k++) begin : gReg
    localparam logic [31:0] RST_VAL = baseReset(k) | (LOCK_EXT[k] ? LOCK_BIT : 32'h0);
    logic [31:0] nextVal;
    always_comb begin
      case (strb.op)
        OP_SET:  nextVal = regArr[k] | wdata;
        OP_CLR:  nextVal = regArr[k] & ~wdata;
        OP_TOG:  nextVal = regArr[k] ^ wdata;
        default: nextVal = wdata;
      endcase
    end
    always_ff @(posedge clk) begin
      if (!rstN)                               regArr[k] <= RST_VAL;
      else if (wrOk && regSel == SEL_W'(k))    regArr[k] <= nextVal;
    end
    assign regFile[32*k +: 32] = regArr[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ready <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      ready <= strb.act;
      err   <= strb.act && strb.err;
      rdata <= (strb.act && !strb.wr && !strb.err) ? selOld : 32'h0;
    end
  end

  AST_SET_OR: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && strb.op == OP_SET) |=> ((regArr[$past(regSel)] & $past(wdata)) == $past(wdata)))
    else $error("AST_SET_OR"); // R2
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && strb.op == OP_CLR) |=> ((regArr[$past(regSel)] & $past(wdata)) == 32'h0))
    else $error("AST_CLR_ZERO"); // R3
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && strb.op == OP_TOG) |=> ((regArr[$past(regSel)] ^ $past(selOld)) == $past(wdata)))
    else $error("AST_TOG_FLIP"); // R4
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.act && strb.err) |=> $stable(regFile)) else $error("AST_ERR_HOLD"); // R8
  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    strb.act |=> ready) else $error("AST_RESP_NEXT"); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.act |=> !ready) else $error("AST_NO_SPURIOUS"); // R10

endmodule

// File: rtl/setclr_reg_bank.sv
module setclr_reg_bank
  import alias_bank_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_GROUPS = 4,
  parameter int NUM_PLAIN  = 2,
  parameter logic [NUM_GROUPS-1:0] LOCK_MASK = 4'b0101
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 busValid,
  input  logic                                 busWrite,
  input  logic [ADDR_W-1:0]                    busAddr,
  input  logic [3:0]                           busByteEn,
  input  logic [31:0]                          busWdata,
  output logic [31:0]                          busRdata,
  output logic                                 busReady,
  output logic                                 busError,
  output logic [(NUM_GROUPS+NUM_PLAIN)*32-1:0] regFile
);
  localparam int NREG  = NUM_GROUPS + NUM_PLAIN;
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

  bankStrb_t        strb;
  logic [SEL_W-1:0] regSel;

  alias_bank_ctrl #(
    .ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS), .NUM_PLAIN(NUM_PLAIN), .SEL_W(SEL_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .strb(strb), .regSel(regSel)
  );

  alias_bank_data #(
    .NUM_GROUPS(NUM_GROUPS), .NUM_PLAIN(NUM_PLAIN), .SEL_W(SEL_W), .LOCK_MASK(LOCK_MASK)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .regSel(regSel), .wdata(busWdata),
    .rdata(busRdata), .ready(busReady), .err(busError), .regFile(regFile)
  );

endmodule

// File: tb/tb_setclr_reg_bank.sv
module tb_setclr_reg_bank;
  localparam int NG = 4;
  localparam int NP = 2;
  localparam int NR = NG + NP;
  localparam int NSLOT = 4 * NG + NP;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busValid = 1'b0;
  logic          busWrite = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [3:0]    busByteEn = 4'hF;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          busReady;
  logic          busError;
  logic [NR*32-1:0] regFile;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;
  logic [31:0] mdl [NR];

  always #5 clk = ~clk;

  setclr_reg_bank dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady), .busError(busError), .regFile(regFile)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [7:0] addr, input logic [3:0] be,
                     input logic [31:0] wd, output logic [31:0] rd,
                     output logic rdy, output logic er);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busByteEn = be; busWdata = wd;
    @(posedge clk); #1;
    rd = busRdata; rdy = busReady; er = busError;
    busValid = 1'b0; busWrite = 1'b0; busByteEn = 4'hF;
  endtask

  task automatic chkFile(input string tag);
    for (int k = 0; k < NR; k++) chk(tag, regFile[32*k +: 32], mdl[k]);
  endtask

  function automatic logic [31:0] expRead(input int idx);
    if (idx < 4 * NG)   return mdl[idx / 4];
    else if (idx < NSLOT) return mdl[NG + idx - 4 * NG];
    else return 32'h0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++; nChk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic rdy, er;
    logic [31:0] pats [4];
    pats[0] = 32'hA5A5_0F0F; pats[1] = 32'hFFFF_0000;
    pats[2] = 32'h0000_0001; pats[3] = 32'h8000_0000;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R9: reset values with the lock bit on groups 0 and 2
    mdl[0] = 32'h8001_3001; mdl[1] = 32'h1018_101B; mdl[2] = 32'h8001_2000;
    mdl[3] = 32'h0; mdl[4] = 32'h0000_0012; mdl[5] = 32'h0;
    chkFile("R9 reset value");
    chk("R10 idle ready", {31'h0, busReady}, 32'h0);

    // R1 R5 R8: sweep every word index with reads
    for (int i = 0; i < 64; i++) begin
      acc(1'b0, 8'(i * 4), 4'hF, 32'h0, rd, rdy, er);
      chk("R5 R1 read sweep data", rd, expRead(i));
      chk("R8 read sweep error", {31'h0, er}, {31'h0, (i >= NSLOT)});
      chk("R10 ready", {31'h0, rdy}, 32'h1);
    end

    // R2 R3 R4 R6: each alias op and pattern, followed at once by a base read
    for (int g = 0; g < NG; g++) begin
      for (int s = 0; s < 4; s++) begin
        for (int p = 0; p < 4; p++) begin
          acc(1'b1, 8'((4 * g + s) * 4), 4'hF, pats[p], rd, rdy, er);
          case (s)
            0: mdl[g] = pats[p];
            1: mdl[g] = mdl[g] | pats[p];
            2: mdl[g] = mdl[g] & ~pats[p];
            default: mdl[g] = mdl[g] ^ pats[p];
          endcase
          acc(1'b0, 8'((4 * g) * 4), 4'hF, 32'h0, rd, rdy, er);
          chk(s == 0 ? "R6 base write" : s == 1 ? "R2 set" : s == 2 ? "R3 clear" : "R4 toggle",
              rd, mdl[g]);
          chk("R11 regFile slice", regFile[32*g +: 32], mdl[g]);
        end
        // R5: the alias slot reads back the base register
        acc(1'b0, 8'((4 * g + s) * 4), 4'hF, 32'h0, rd, rdy, er);
        chk("R5 alias read", rd, mdl[g]);
      end
    end

    // R6: plain registers replace the whole value
    for (int p = 0; p < NP; p++) begin
      acc(1'b1, 8'((4 * NG + p) * 4), 4'hF, 32'hDEAD_0000 + 32'(p), rd, rdy, er);
      mdl[NG + p] = 32'hDEAD_0000 + 32'(p);
      acc(1'b1, 8'((4 * NG + p) * 4), 4'hF, 32'h1234_5678, rd, rdy, er);
      mdl[NG + p] = 32'h1234_5678;
      acc(1'b0, 8'((4 * NG + p) * 4), 4'hF, 32'h0, rd, rdy, er);
      chk("R6 plain write", rd, mdl[NG + p]);
    end
    chkFile("R11 regFile after plain");

    // R7: misaligned and partial accesses
    for (int b = 1; b < 4; b++) begin
      acc(1'b1, 8'(4 + b), 4'hF, 32'hFFFF_FFFF, rd, rdy, er);
      chk("R7 misaligned error", {31'h0, er}, 32'h1);
      acc(1'b0, 8'(b), 4'hF, 32'h0, rd, rdy, er);
      chk("R7 misaligned read data", rd, 32'h0);
    end
    acc(1'b1, 8'h0C, 4'h7, 32'hFFFF_FFFF, rd, rdy, er);
    chk("R7 partial enable error", {31'h0, er}, 32'h1);
    acc(1'b1, 8'h00, 4'h0, 32'h0000_0000, rd, rdy, er);
    chk("R7 no enable error", {31'h0, er}, 32'h1);
    chkFile("R7 state unchanged");

    // R8: out-of-range writes
    acc(1'b1, 8'(NSLOT * 4), 4'hF, 32'hFFFF_FFFF, rd, rdy, er);
    chk("R8 range error", {31'h0, er}, 32'h1);
    acc(1'b1, 8'hFC, 4'hF, 32'h0, rd, rdy, er);
    chk("R8 top error", {31'h0, er}, 32'h1);
    chkFile("R8 state unchanged");

    // R10: no request gives no ready
    @(posedge clk); #1;
    chk("R10 idle after traffic", {31'h0, busReady}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule